// File: doc/BRIEF.md
# UART Receive-Error and Event Status Register

This block is the 16-bit status word of a serial port whose receiver stores bytes in a 16-entry FIFO. It keeps a parity-error bit and a framing-error bit alongside every byte held in that FIFO. The upper byte of the status word gives live counts of the stored bytes that carry each kind of error. Bits 3 and 2 show the error bits of the byte at the FIFO head.

The low byte also holds six sticky event flags. The transmitter and receiver raise them through single-cycle (or level) event inputs: error, transmit end, transmit FIFO below threshold, break, receive FIFO at threshold, and receive data ready. Software can only clear a flag, and only by writing 0 to it after it has read that flag as 1. A stray write of 0 therefore cannot discard an event that software has not yet seen.

The CPU port reads and writes at any time. The read data is combinational from the stored state.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the status word reads 0x0060: transmit-end and transmit-threshold flags are 1, and every other bit, including both counts, is 0.
- R2: The event flags sit at bit 7 error, bit 6 transmit end, bit 5 transmit threshold, bit 4 break, bit 1 receive threshold, bit 0 data ready. An event input held high sets its flag in the next cycle, and the flag stays set after the input falls.
- R3: A CPU write never sets a flag; writing 1 to a flag bit leaves it unchanged.
- R4: Writing 0 to a flag clears it only if the CPU has read that flag as 1 since it was last cleared; otherwise the write is ignored. A clearing write uses up that read, so a later write of 0 needs a new read of 1.
- R5: When a set event arrives in the same cycle as a clearing write of the same flag, the flag stays 1.
- R6: Bit 3 shows the framing-error bit and bit 2 the parity-error bit of the byte at the receive FIFO head. Both read 0 when the FIFO is empty. CPU writes do not change them.
- R7: Bits 15:12 count the stored bytes with a parity error and bits 11:8 count those with a framing error. A push adds the new byte's bits, a pop removes the head byte's bits, and a push with a pop in the same cycle applies the net change.
- R8: The counts are 4 bits and wrap, so 16 stored bytes that all carry an error read as a count of 0.
- R9: A push into a full FIFO without a pop in the same cycle is discarded. A pop from an empty FIFO has no effect. A push with a pop into a full FIFO is accepted.
- R10: CPU writes do not change either count field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-on or manual) |
| cpuRd | input | 1 | CPU read strobe for the status word |
| cpuWr | input | 1 | CPU write strobe for the status word |
| cpuWdata | input | 16 | CPU write data |
| cpuRdata | output | 16 | Status word |
| evtEr | input | 1 | Receive error event |
| evtTend | input | 1 | Transmit end event |
| evtTdfe | input | 1 | Transmit FIFO below threshold event |
| evtBrk | input | 1 | Break detected event |
| evtRdf | input | 1 | Receive FIFO at threshold event |
| evtDr | input | 1 | Receive data ready event |
| rxPush | input | 1 | A byte enters the receive FIFO |
| rxPushPer | input | 1 | Parity error of the entering byte |
| rxPushFer | input | 1 | Framing error of the entering byte |
| rxPop | input | 1 | The head byte leaves the receive FIFO |

## Verification
The hardest state to reach is the wrapped count: sixteen error bytes stored, so the field reads 0 while the head still shows both error bits. The next step is a simultaneous push and pop at full, which makes the count drop to 15. The bench gets there by pushing sixteen doubly errored bytes and then driving a push with a pop of a clean byte. A queue model of the FIFO predicts both counts and the head bits after each step. The second hard case is a set event that lands in the same cycle as an armed clearing write. The bench arms the flag with a read, then drives the event and the write of 0 together.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  localparam int NUM_FLAGS = 6;
  localparam logic [15:0] RESET_WORD = 16'h0060;

  // flag vector order: [5] err, [4] tx end, [3] tx threshold, [2] break,
  // [1] rx threshold, [0] data ready
  function automatic logic [NUM_FLAGS-1:0] flagsOf(input logic [15:0] word);
    return {word[7:4], word[1:0]};
  endfunction

  localparam logic [NUM_FLAGS-1:0] RESET_FLAGS = flagsOf(RESET_WORD);

  typedef struct packed {
    logic push;
    logic pop;
    logic pushPer;
    logic pushFer;
    logic headValid;
  } rxStrobe_t;

endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuRd,
  input  logic                 cpuWr,
  input  logic [NUM_FLAGS-1:0] wrFlags,
  input  logic [NUM_FLAGS-1:0] setEvt,
  input  logic                 rxPush,
  input  logic                 rxPushPer,
  input  logic                 rxPushFer,
  input  logic                 rxPop,
  output logic [NUM_FLAGS-1:0] flagQ,
  output rxStrobe_t            strobe
);

  localparam int OCC_W = $clog2(DEPTH) + 1;

  logic [OCC_W-1:0] occQ;
  logic             isFull;
  logic             isEmpty;
  logic             pushOk;
  logic             popOk;

  assign isFull  = (occQ == OCC_W'(DEPTH));
  assign isEmpty = (occQ == '0);
  assign popOk   = rxPop && !isEmpty;
  assign pushOk  = rxPush && (!isFull || popOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
    end else if (pushOk && !popOk) begin
      occQ <= occQ + 1'b1;
    end else if (popOk && !pushOk) begin
      occQ <= occQ - 1'b1;
    end
  end

  always_comb begin
    strobe.push      = pushOk;
    strobe.pop       = popOk;
    strobe.pushPer   = rxPushPer;
    strobe.pushFer   = rxPushFer;
    strobe.headValid = !isEmpty;
  end

  // one sticky flag with its read-as-one tag per bit
  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    logic tagQ;
    logic clrHit;

    assign clrHit = cpuWr && !wrFlags[gi] && tagQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[gi] <= RESET_FLAGS[gi];
        tagQ      <= 1'b0;
      end else begin
        flagQ[gi] <= setEvt[gi] | (flagQ[gi] & ~clrHit);
        if (clrHit) begin
          tagQ <= 1'b0;
        end else if (cpuRd && flagQ[gi]) begin
          tagQ <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_err_store.sv
module rx_err_store
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  output logic [CNT_W-1:0] perCnt,
  output logic [CNT_W-1:0] ferCnt,
  output logic             headPer,
  output logic             headFer
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [1:0]       errMem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [1:0]       headBits;
  logic [CNT_W-1:0] perAdd;
  logic [CNT_W-1:0] perSub;
  logic [CNT_W-1:0] ferAdd;
  logic [CNT_W-1:0] ferSub;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headBits = errMem[rdPtr];
  assign headPer  = strobe.headValid & headBits[1];
  assign headFer  = strobe.headValid & headBits[0];

  assign perAdd = CNT_W'(strobe.push & strobe.pushPer);
  assign ferAdd = CNT_W'(strobe.push & strobe.pushFer);
  assign perSub = CNT_W'(strobe.pop & headBits[1]);
  assign ferSub = CNT_W'(strobe.pop & headBits[0]);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      errMem[wrPtr] <= {strobe.pushPer, strobe.pushFer};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      perCnt <= '0;
      ferCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      perCnt <= perCnt + perAdd - perSub;
      ferCnt <= ferCnt + ferAdd - ferSub;
    end
  end

endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic [15:0] cpuWdata,
  output logic [15:0] cpuRdata,
  input  logic        evtEr,
  input  logic        evtTend,
  input  logic        evtTdfe,
  input  logic        evtBrk,
  input  logic        evtRdf,
  input  logic        evtDr,
  input  logic        rxPush,
  input  logic        rxPushPer,
  input  logic        rxPushFer,
  input  logic        rxPop
);

  localparam int FIELD_W = 4;

  rxStrobe_t            strobe;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] setEvt;
  logic [FIELD_W-1:0]   perCnt;
  logic [FIELD_W-1:0]   ferCnt;
  logic                 headPer;
  logic                 headFer;

  assign setEvt = {evtEr, evtTend, evtTdfe, evtBrk, evtRdf, evtDr};

  stat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuRd    (cpuRd),
    .cpuWr    (cpuWr),
    .wrFlags  (flagsOf(cpuWdata)),
    .setEvt   (setEvt),
    .rxPush   (rxPush),
    .rxPushPer(rxPushPer),
    .rxPushFer(rxPushFer),
    .rxPop    (rxPop),
    .flagQ    (flagQ),
    .strobe   (strobe)
  );

  rx_err_store #(.DEPTH(DEPTH), .CNT_W(FIELD_W)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .perCnt (perCnt),
    .ferCnt (ferCnt),
    .headPer(headPer),
    .headFer(headFer)
  );

  assign cpuRdata = {perCnt, ferCnt, flagQ[5:2], headFer, headPer, flagQ[1:0]};

endmodule

// File: rtl/uart_stat_reg_chk.sv
module uart_stat_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuRdata,
  input logic        evtEr,
  input logic        evtTend,
  input logic        evtTdfe,
  input logic        evtBrk,
  input logic        evtRdf,
  input logic        evtDr,
  input logic        rxPush,
  input logic        rxPop
);

  logic [5:0] flagNow;
  logic [5:0] evtNow;

  assign flagNow = {cpuRdata[7:4], cpuRdata[1:0]};
  assign evtNow  = {evtEr, evtTend, evtTdfe, evtBrk, evtRdf, evtDr};

  for (genvar gi = 0; gi < 6; gi++) begin : g_chk
    // R3: a clear flag with no set event stays clear whatever is written
    assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!flagNow[gi] && !evtNow[gi]) |=> !flagNow[gi]);

    // R2 and R5: a set event always shows as 1 in the next cycle
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtNow[gi] |=> flagNow[gi]);
  end

  // R10: without FIFO traffic the count fields hold
  assert_counts_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!rxPush && !rxPop) |=> $stable(cpuRdata[15:8]));

  // R7: a count moves by at most one per cycle (modulo 16)
  assert_per_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((4'(cpuRdata[15:12] - $past(cpuRdata[15:12])) inside {4'd0, 4'd1, 4'd15})));

  assert_fer_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((4'(cpuRdata[11:8] - $past(cpuRdata[11:8])) inside {4'd0, 4'd1, 4'd15})));

endmodule

bind uart_stat_reg uart_stat_reg_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuRdata(cpuRdata),
  .evtEr   (evtEr),
  .evtTend (evtTend),
  .evtTdfe (evtTdfe),
  .evtBrk  (evtBrk),
  .evtRdf  (evtRdf),
  .evtDr   (evtDr),
  .rxPush  (rxPush),
  .rxPop   (rxPop)
);

// File: tb/uart_stat_reg_tb.sv
module uart_stat_reg_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic [5:0]  evt = '0;
  logic        rxPush = 1'b0;
  logic        rxPushPer = 1'b0;
  logic        rxPushFer = 1'b0;
  logic        rxPop = 1'b0;

  int total = 0;
  int bad = 0;
  logic [1:0] mdlQ[$];

  uart_stat_reg u_dut (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .evtEr(evt[5]), .evtTend(evt[4]), .evtTdfe(evt[3]), .evtBrk(evt[2]),
    .evtRdf(evt[1]), .evtDr(evt[0]),
    .rxPush(rxPush), .rxPushPer(rxPushPer), .rxPushFer(rxPushFer), .rxPop(rxPop)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // each driver task starts and ends at a negedge
  task automatic doRead();
    cpuRd = 1'b1; @(negedge clk); cpuRd = 1'b0;
  endtask

  task automatic doWrite(input logic [15:0] d);
    cpuWr = 1'b1; cpuWdata = d; @(negedge clk); cpuWr = 1'b0;
  endtask

  task automatic doEvt(input logic [5:0] e);
    evt = e; @(negedge clk); evt = '0;
  endtask

  task automatic doFifo(input logic push, input logic per, input logic fer, input logic pop);
    rxPush = push; rxPushPer = per; rxPushFer = fer; rxPop = pop;
    @(negedge clk);
    rxPush = 1'b0; rxPushPer = 1'b0; rxPushFer = 1'b0; rxPop = 1'b0;
    if (pop && mdlQ.size() > 0) void'(mdlQ.pop_front());
    if (push && mdlQ.size() < 16) mdlQ.push_back({per, fer});
  endtask

  task automatic checkFifo(input string tag);
    logic [3:0] p = 0;
    logic [3:0] f = 0;
    logic [1:0] h = 0;
    foreach (mdlQ[i]) begin
      p = p + 4'(mdlQ[i][1]);
      f = f + 4'(mdlQ[i][0]);
    end
    if (mdlQ.size() > 0) h = mdlQ[0];
    check(tag, {cpuRdata[15:8], 4'h0, cpuRdata[3:2], 2'b00}, {p, f, 4'h0, h[0], h[1], 2'b00});
  endtask

  task automatic testReset();
    check("R1 reset word", cpuRdata, 16'h0060);
  endtask

  task automatic testNoSet();
    doWrite(16'hFFFF);
    check("R3 write ones sets nothing", cpuRdata, 16'h0060);
  endtask

  task automatic testClearNeedsRead();
    doWrite(16'h0000);
    check("R4 clear without read ignored", cpuRdata, 16'h0060);
    doRead();
    doWrite(16'h0000);
    check("R4 clear after read", cpuRdata, 16'h0000);
    doEvt(6'b000100);
    doWrite(16'h0000);
    check("R4 break clear without read", cpuRdata, 16'h0010);
    doRead();
    doWrite(16'hFFEF);
    check("R4 break cleared by its own zero", cpuRdata, 16'h0000);
    doEvt(6'b000100);
    doWrite(16'h0000);
    check("R4 tag consumed by clear", cpuRdata, 16'h0010);
    doRead();
    doWrite(16'h0000);
    check("R4 break cleared again", cpuRdata, 16'h0000);
  endtask

  task automatic testEvents();
    logic [7:0] pos [6] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h02, 8'h01};
    for (int i = 0; i < 6; i++) begin
      doEvt(6'(1 << (5 - i)));
      @(negedge clk);
      check("R2 flag position sticky", cpuRdata, {8'h00, pos[i]});
      doRead();
      doWrite(16'h0000);
    end
    check("R2 all cleared", cpuRdata, 16'h0000);
  endtask

  task automatic testSetWins();
    doEvt(6'b000001);
    doRead();
    evt = 6'b000001; cpuWr = 1'b1; cpuWdata = 16'h0000;
    @(negedge clk);
    evt = '0; cpuWr = 1'b0;
    check("R5 set beats clear", cpuRdata, 16'h0001);
    doRead();
    doWrite(16'h0000);
    check("R5 later clear works", cpuRdata, 16'h0000);
  endtask

  task automatic testFifo();
    doFifo(1, 1, 0, 0); checkFifo("R7 push parity");
    check("R6 head parity bit", {14'h0, cpuRdata[3:2]}, 16'h0001);
    doFifo(1, 0, 1, 0); checkFifo("R7 push framing");
    doFifo(1, 1, 1, 0); checkFifo("R7 push both");
    doFifo(1, 0, 0, 0); checkFifo("R7 push clean");
    doWrite(16'h0000);
    checkFifo("R10 write keeps counts");
    doWrite(16'hFFFF);
    checkFifo("R6 write keeps head bits");
    doFifo(1, 0, 1, 1); checkFifo("R7 push and pop net");
    doFifo(0, 0, 0, 1); checkFifo("R6 head after pop");
    doFifo(0, 0, 0, 1); checkFifo("R7 pop both");
    doFifo(0, 0, 0, 1); checkFifo("R7 pop clean");
    doFifo(0, 0, 0, 1); checkFifo("R6 last pop empty");
    check("R6 empty head zero", cpuRdata, 16'h0000);
  endtask

  task automatic testWrap();
    for (int i = 0; i < 16; i++) doFifo(1, 1, 1, 0);
    checkFifo("R8 sixteen errors wrap");
    check("R8 wrapped word", cpuRdata, 16'h000C);
    doFifo(1, 0, 0, 0);
    check("R9 push when full dropped", cpuRdata, 16'h000C);
    doFifo(1, 0, 0, 1);
    check("R9 push with pop at full", cpuRdata[15:8], 16'h00FF);
    checkFifo("R9 model after full push pop");
    for (int i = 0; i < 16; i++) doFifo(0, 0, 0, 1);
    checkFifo("R9 drained");
    doFifo(0, 0, 0, 1);
    check("R9 pop when empty", cpuRdata, 16'h0000);
    doFifo(1, 1, 0, 0);
    check("R9 push after empty pop", cpuRdata, 16'h1004);
    doFifo(0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoSet();
    testClearNeedsRead();
    testEvents();
    testSetWins();
    testFifo();
    testWrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule